// File: doc/BRIEF.md
# Signed Halfword Divide Unit with Condition Flags

This block divides a 32-bit signed dividend by a 16-bit signed divisor and reports the result with a set of condition flags. The divisor comes from the low half of a 32-bit operand and is sign-extended, so the upper half of that operand has no effect. The quotient is rounded toward zero. A normal divide takes one quotient bit per cycle as a restoring shift-subtract on magnitudes. The sign is applied in a final cycle.

Two cases cannot give a quotient: a zero divisor, and the most negative dividend divided by minus one. Both are found in the cycle that takes the start request. They finish one cycle later with the overflow flag set and the write enable low, so the destination keeps its value. The incoming carry and saturation flags always pass through unchanged.

A caller pulses `start` while `busy` is low. Results are valid during the single cycle in which `done` is high. A caller writes the quotient back only when `wr_en` is high in that cycle.

Top module: `hdiv_unit`

## Requirements
- R1: Only bits 15:0 of `divisor_op` are used, sign-extended to 32 bits. 0x0000FFFA acts as -6, 0xABCD0006 acts as 6, and 0x1234FFFF acts as -1.
- R2: For a nonzero divisor, outside the R5 case, `quotient` is the signed dividend divided by the sign-extended divisor, truncated toward zero, and `wr_en` is 1 in the `done` cycle. For example, 45/6 gives 7, -45/6 gives -7, 45/-6 gives -7 and -45/-6 gives 7.
- R3: On a normal result, the flag bits (bit 2 overflow, bit 1 sign, bit 0 zero) are set as follows: overflow is 0, sign is quotient bit 31, and zero is 1 exactly when the quotient is 0. A zero dividend is a normal case.
- R4: A zero divisor gives `wr_en`=0 and overflow=1. The sign and zero flags keep their incoming values, and `quotient` shows the unchanged dividend.
- R5: A dividend of 0x80000000 with a divisor of -1 gives `wr_en`=0, overflow=1, sign=1 and zero=0. `quotient` shows 0x80000000.
- R6: Flag bit 4 (saturation) and bit 3 (carry) of `flags_out` equal those of `flags_in` sampled with `start`, in every case.
- R7: For R4 and R5, `done` is high in the cycle right after the edge that samples `start`, and `busy` stays low. For a normal divide, `busy` is high from that edge on, and `done` rises 33 edges after the edge that samples `start`.
- R8: `start` is ignored while `busy` is high. The running divide finishes with its own result and latency, and no extra `done` follows.
- R9: After reset, `busy`, `done` and `wr_en` are 0. `done` is high for one cycle per operation. `wr_en` is never high without `done`, and `done` is never high together with `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a divide; sampled only when idle |
| dividend | input | 32 | Signed dividend (destination's current value) |
| divisor_op | input | 32 | Operand whose low 16 bits form the divisor |
| flags_in | input | 5 | Incoming flags {sat, carry, overflow, sign, zero} |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle result-valid pulse |
| quotient | output | 32 | Quotient, or unchanged dividend on an exception |
| wr_en | output | 1 | Destination write enable, valid with done |
| flags_out | output | 5 | Outgoing flags {sat, carry, overflow, sign, zero} |

## Verification
Each scenario task raises `start` at a falling edge and counts rising edges, including the one that samples `start`, until `done` is seen at a falling edge. The count must be 1 for a zero divisor or the minimum-by-minus-one case, and 34 for any normal divide. The quotient, write enable and flags are read in that same half-cycle. `done` is checked low again one cycle later. `busy` is checked at the first falling edge after the sampled start, and the busy-ignore scenario injects a second start partway through the run and still expects the first operation's result at the unchanged count.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;
    localparam int DATA_W = 32;
    localparam int DIVS_W = 16;
    localparam int CNT_W  = $clog2(DATA_W);

    typedef struct packed {
        logic sat;
        logic carry;
        logic ovf;
        logic sign;
        logic zero;
    } flags_t;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_t;

    typedef struct packed {
        logic              div_zero;
        logic              min_ovf;
        logic              neg;
        logic [DATA_W-1:0] mag_dvd;
        logic [DATA_W-1:0] mag_dvs;
    } prep_t;

    function automatic logic [DATA_W-1:0] mag_of(input logic [DATA_W-1:0] v);
        return v[DATA_W-1] ? (~v + 1'b1) : v;
    endfunction
endpackage

// File: rtl/hdiv_prep.sv
module hdiv_prep
    import hdiv_pkg::*;
(
    input  logic [DATA_W-1:0] dividend,
    input  logic [DATA_W-1:0] divisor_op,
    output prep_t             prep
);
    logic [DATA_W-1:0] dvs_ext;

    always_comb begin
        dvs_ext       = {{(DATA_W-DIVS_W){divisor_op[DIVS_W-1]}}, divisor_op[DIVS_W-1:0]};
        prep.div_zero = (dvs_ext == '0);
        prep.min_ovf  = (dividend == {1'b1, {(DATA_W-1){1'b0}}}) && (dvs_ext == '1);
        prep.neg      = dividend[DATA_W-1] ^ dvs_ext[DATA_W-1];
        prep.mag_dvd  = mag_of(dividend);
        prep.mag_dvs  = mag_of(dvs_ext);
    end
endmodule

// File: rtl/hdiv_core.sv
module hdiv_core
    import hdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [DATA_W-1:0] mag_dvd,
    input  logic [DATA_W-1:0] mag_dvs,
    output logic [DATA_W-1:0] quo_mag,
    output logic              last
);
    logic [DATA_W:0]   rem;
    logic [DATA_W-1:0] quo;
    logic [DATA_W-1:0] dvs;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W:0]   shifted;
    logic [DATA_W+1:0] diff;
    logic              fits;

    always_comb begin
        shifted = {rem[DATA_W-1:0], quo[DATA_W-1]};
        diff    = {1'b0, shifted} - {2'b00, dvs};
        fits    = ~diff[DATA_W+1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
            quo <= '0;
            dvs <= '0;
            cnt <= '0;
        end else if (load) begin
            rem <= '0;
            quo <= mag_dvd;
            dvs <= mag_dvs;
            cnt <= '0;
        end else if (step) begin
            rem <= fits ? diff[DATA_W:0] : shifted;
            quo <= {quo[DATA_W-2:0], fits};
            cnt <= cnt + 1'b1;
        end
    end

    assign quo_mag = quo;
    assign last    = (cnt == CNT_W'(DATA_W-1));

    // R2: partial remainder stays below the divisor after every step
    assert_rem_below_divisor_R2: assert property (@(posedge clk) disable iff (rst)
        $past(step) |-> (rem < {1'b0, dvs}));
endmodule

// File: rtl/hdiv_flags.sv
module hdiv_flags
    import hdiv_pkg::*;
(
    input  flags_t            fin,
    input  logic              div_zero,
    input  logic              min_ovf,
    input  logic [DATA_W-1:0] result,
    output flags_t            fout
);
    always_comb begin
        fout       = fin;
        fout.ovf   = 1'b1;
        if (min_ovf) begin
            fout.sign = 1'b1;
            fout.zero = 1'b0;
        end else if (!div_zero) begin
            fout.ovf  = 1'b0;
            fout.sign = result[DATA_W-1];
            fout.zero = (result == '0);
        end
    end
endmodule

// File: rtl/hdiv_unit.sv
module hdiv_unit
    import hdiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] dividend,
    input  logic [31:0] divisor_op,
    input  logic [4:0]  flags_in,
    output logic        busy,
    output logic        done,
    output logic [31:0] quotient,
    output logic        wr_en,
    output logic [4:0]  flags_out
);
    state_t            state;
    prep_t             prep;
    flags_t            flags_hold;
    flags_t            fl_src;
    flags_t            fl_new;
    logic              neg_q;
    logic              accept;
    logic              special;
    logic              fin_sel;
    logic [DATA_W-1:0] quo_mag;
    logic [DATA_W-1:0] signed_q;
    logic [DATA_W-1:0] fl_result;
    logic              core_last;

    hdiv_prep u_prep (
        .dividend   (dividend),
        .divisor_op (divisor_op),
        .prep       (prep)
    );

    always_comb begin
        accept    = start && (state == ST_IDLE);
        special   = prep.div_zero || prep.min_ovf;
        fin_sel   = (state == ST_FIN);
        signed_q  = neg_q ? (~quo_mag + 1'b1) : quo_mag;
        fl_src    = fin_sel ? flags_hold : flags_t'(flags_in);
        fl_result = fin_sel ? signed_q : dividend;
    end

    hdiv_core u_core (
        .clk     (clk),
        .rst     (rst),
        .load    (accept && !special),
        .step    (state == ST_RUN),
        .mag_dvd (prep.mag_dvd),
        .mag_dvs (prep.mag_dvs),
        .quo_mag (quo_mag),
        .last    (core_last)
    );

    hdiv_flags u_flags (
        .fin      (fl_src),
        .div_zero (!fin_sel && prep.div_zero),
        .min_ovf  (!fin_sel && prep.min_ovf),
        .result   (fl_result),
        .fout     (fl_new)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            done       <= 1'b0;
            wr_en      <= 1'b0;
            quotient   <= '0;
            flags_out  <= '0;
            flags_hold <= '0;
            neg_q      <= 1'b0;
        end else begin
            done  <= 1'b0;
            wr_en <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    if (special) begin
                        done      <= 1'b1;
                        quotient  <= dividend;
                        flags_out <= fl_new;
                    end else begin
                        state      <= ST_RUN;
                        flags_hold <= flags_t'(flags_in);
                        neg_q      <= prep.neg;
                    end
                end
                ST_RUN: if (core_last) state <= ST_FIN;
                ST_FIN: begin
                    state     <= ST_IDLE;
                    done      <= 1'b1;
                    wr_en     <= 1'b1;
                    quotient  <= signed_q;
                    flags_out <= fl_new;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

    // R9: no result pulse while a divide is running
    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R9: write enable only inside a done pulse
    assert_wr_with_done_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> done);
    // R4: zero divisor finishes next cycle without write-back
    assert_zero_div_R4: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && prep.div_zero) |=> (done && !wr_en && flags_out[2]));
    // R5: minimum by minus one finishes next cycle with overflow and sign
    assert_min_ovf_R5: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && prep.min_ovf) |=> (done && !wr_en && flags_out[2] && flags_out[1]));
    // R3: a written result never reports overflow
    assert_normal_no_ovf_R3: assert property (@(posedge clk) disable iff (rst)
        (done && wr_en) |-> !flags_out[2]);
    // R7: an accepted normal divide raises busy on the next cycle
    assert_busy_after_start_R7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !special) |=> busy);
endmodule

// File: tb/hdiv_unit_tb.sv
module hdiv_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor_op = '0;
    logic [4:0]  flags_in = '0;
    logic        busy, done, wr_en;
    logic [31:0] quotient;
    logic [4:0]  flags_out;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    hdiv_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .dividend(dividend),
        .divisor_op(divisor_op), .flags_in(flags_in), .busy(busy), .done(done),
        .quotient(quotient), .wr_en(wr_en), .flags_out(flags_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference model from the requirements
    task automatic model(input logic [31:0] dvd, input logic [31:0] dvs, input logic [4:0] fin,
                         output logic [31:0] q, output logic we, output logic [4:0] fl,
                         output int lat);
        logic signed [31:0] a, b, r;
        a = dvd;
        b = {{16{dvs[15]}}, dvs[15:0]};
        if (b == 0) begin
            q = dvd; we = 1'b0; fl = {fin[4:3], 1'b1, fin[1:0]}; lat = 1;
        end else if (dvd == 32'h8000_0000 && b == -1) begin
            q = dvd; we = 1'b0; fl = {fin[4:3], 3'b110}; lat = 1;
        end else begin
            r = a / b;
            q = r; we = 1'b1; fl = {fin[4:3], 1'b0, r[31], (r == 0)}; lat = 34;
        end
    endtask

    // inject: raise start again with a zero divisor at this many cycles into the run (0 = none)
    task automatic run_case(input logic [31:0] dvd, input logic [31:0] dvs, input logic [4:0] fin,
                            input string req, input int inject);
        logic [31:0] eq; logic ewe; logic [4:0] efl; int elat;
        int cnt;
        model(dvd, dvs, fin, eq, ewe, efl, elat);
        @(negedge clk);
        start = 1'b1; dividend = dvd; divisor_op = dvs; flags_in = fin;
        @(posedge clk);
        cnt = 1;
        @(negedge clk);
        start = 1'b0; dividend = '0; divisor_op = '0; flags_in = '0;
        chk(busy == (elat != 1), "R7", "busy after start", 32'(busy), 32'(elat != 1));
        while (!done && cnt < 100) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (inject != 0 && cnt == inject) begin
                start = 1'b1; dividend = 32'h8000_0000; divisor_op = 32'h0;
            end else begin
                start = 1'b0; dividend = '0; divisor_op = '0;
            end
        end
        chk(cnt == elat, req, "latency", 32'(cnt), 32'(elat));
        chk(quotient == eq, req, "quotient", quotient, eq);
        chk(wr_en == ewe, req, "wr_en", 32'(wr_en), 32'(ewe));
        chk(flags_out == efl, req, "flags", 32'(flags_out), 32'(efl));
        chk(flags_out[4:3] == fin[4:3], "R6", "sat/carry", 32'(flags_out[4:3]), 32'(fin[4:3]));
        start = 1'b0;
        @(negedge clk);
        chk(!done, "R9", "done single pulse", 32'(done), 32'd0);
        if (inject != 0) begin
            repeat (3) begin
                @(negedge clk);
                chk(!done && !busy, "R8", "no extra op", {busy, done}, 32'd0);
            end
        end
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(!busy && !done && !wr_en, "R9", "reset state", {busy, done, wr_en}, 32'd0);
    endtask

    task automatic t_signs;
        run_case(32'd45,       32'd6,          5'b00000, "R2", 0);
        run_case(-32'sd45,     32'd6,          5'b10000, "R2", 0);
        run_case(32'd45,       -32'sd6,        5'b01000, "R3", 0);
        run_case(-32'sd45,     -32'sd6,        5'b11111, "R3", 0);
        run_case(32'h8000_0000, 32'd1,         5'b00100, "R2", 0);
        run_case(32'd1000,     32'd32767,      5'b00010, "R3", 0);
    endtask

    task automatic t_low_half;
        run_case(-32'sd45,     32'h0000_FFFA,  5'b00000, "R1", 0);
        run_case(32'd45,       32'hABCD_0006,  5'b00000, "R1", 0);
    endtask

    task automatic t_zero_dividend;
        run_case(32'd0,        32'd45,         5'b00110, "R3", 0);
    endtask

    task automatic t_div_zero;
        run_case(32'd45,       32'h0000_0000,  5'b00000, "R4", 0);
        run_case(32'd45,       32'hFFFF_0000,  5'b11111, "R4", 0);
    endtask

    task automatic t_min_ovf;
        run_case(32'h8000_0000, 32'hFFFF_FFFF, 5'b00000, "R5", 0);
        run_case(32'h8000_0000, 32'h1234_FFFF, 5'b11001, "R5", 0);
    endtask

    task automatic t_busy_ignore;
        run_case(32'd100,      32'd7,          5'b01000, "R8", 5);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        t_reset();
        t_signs();
        t_low_half();
        t_zero_dividend();
        t_div_zero();
        t_min_ovf();
        t_busy_ignore();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule